// File: doc/BRIEF.md
# Configurable ADC Clock Generator

This block generates the conversion clock shared by a group of ADCs. The clock comes from one of two sources. The first is an asynchronous kernel clock passed through a programmable prescaler whose ratios are 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 or 256. The second is the bus clock divided by 1, 2 or 4. In the bus-derived modes the prescaler is bypassed. Because the conversion clock is then locked to the bus clock, a timer trigger reaches the start of a conversion with a fixed delay. Dividing the bus clock by 1 is only valid when the bus clock is undivided and has a 50% duty cycle.

A small control word, written and read in the bus clock domain, holds the clock-mode field and the prescaler field. It also holds three independent enable flags for the internal-reference, temperature-sensor and battery-monitor channels. The clock fields are locked while any converter reports activity on any of its six activity flags: enabled, regular start, injected start, stop, disable or calibrate. A write during that time leaves both clock fields unchanged, but the channel flags are still written. The prescaler field never takes one of the reserved codes.

Top module: `adc_clkgen_top`

## Requirements
- R1: After reset the control word reads 0 and `adc_clk` follows the kernel clock undivided, which is mode 0 with prescaler code 0.
- R2: The control word is laid out as mode in bits [1:0], prescaler code in bits [5:2], internal-reference enable in bit 6, temperature-sensor enable in bit 7 and battery-monitor enable in bit 8. A write appears on `rd_data` and on the three channel-enable outputs one bus clock edge later.
- R3: In mode 0, prescaler codes 0 to 11 give an `adc_clk` period of 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256 kernel clock periods. Every ratio above 1 has a 50% duty cycle.
- R4: Modes 1, 2 and 3 give an `adc_clk` period of 1, 2 and 4 bus clock periods, whatever the prescaler code.
- R5: While any bit of `act_flags` is high, a write leaves the mode and prescaler fields unchanged, and the channel-enable bits still take the written values.
- R6: A write of a prescaler code from 12 to 15 leaves the prescaler field at its old value. The mode and channel bits of the same write are still applied.
- R7: The bus-derived outputs for divide by 2 and divide by 4 have a 50% duty cycle.
- R8: Once all activity flags are low again, a write updates the mode and prescaler fields normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock: clocks the control word and the bus dividers |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| clk_kern | input | 1 | Asynchronous kernel clock |
| rst_kern_n | input | 1 | Synchronous active-low reset, kernel domain |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 9 | Value to write (layout as in R2) |
| act_flags | input | N_ADC*6 | Six activity flags per converter; any high bit locks the clock fields |
| rd_data | output | 9 | Current control word |
| ch_iref_en | output | 1 | Internal-reference channel enable |
| ch_tsens_en | output | 1 | Temperature-sensor channel enable |
| ch_batmon_en | output | 1 | Battery-monitor channel enable |
| adc_clk | output | 1 | Generated conversion clock |

## Verification
A write is registered on the bus clock edge at which the strobe is high, so the bench reads `rd_data` and the channel outputs at the next falling edge of the bus clock. A prescaler change crosses into the kernel domain through two flops, and the divider may still be partway through its longest half period. For that reason the bench waits 600 kernel cycles after a prescaler write before it times one full `adc_clk` period and its high phase. After a mode change the bench waits ten bus cycles and skips the first rising edge before it measures, so a truncated pulse at the switch is never timed.

// File: rtl/adc_clk_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, control-word layout and the prescaler ratio decode.
// Assumes the control word is nine bits, as laid out in ctl_word_t.
package adc_clk_pkg;
    localparam int MODE_W        = 2;
    localparam int PRESC_W       = 4;
    localparam int WORD_W        = MODE_W + PRESC_W + 3;
    localparam int NUM_CODES     = 12;
    localparam int FLAGS_PER_ADC = 6;
    localparam int HALF_W        = 8;
    localparam int BUS_TAPS      = 2;

    typedef enum logic [MODE_W-1:0] {
        CKM_KERNEL = 2'd0,
        CKM_BUS_D1 = 2'd1,
        CKM_BUS_D2 = 2'd2,
        CKM_BUS_D4 = 2'd3
    } ckmode_e;

    typedef struct packed {
        logic               batmon_on;
        logic               tsens_on;
        logic               iref_on;
        logic [PRESC_W-1:0] presc;
        ckmode_e            mode;
    } ctl_word_t;

    // Tells whether a prescaler code is one of the defined ones.
    function automatic logic code_valid(input logic [PRESC_W-1:0] code);
        return (int'(code) < NUM_CODES);
    endfunction

    // Returns half of the divide ratio, counted in kernel cycles.
    // Code 0 (bypass) and the reserved codes return 1.
    function automatic logic [HALF_W-1:0] half_count(input logic [PRESC_W-1:0] code);
        logic [HALF_W-1:0] h;
        if (code == '0 || !code_valid(code))
            h = HALF_W'(1);
        else if (code <= PRESC_W'(6))
            h = HALF_W'(code);
        else
            h = HALF_W'(1) << (code - PRESC_W'(4));
        return h;
    endfunction
endpackage

// File: rtl/adc_ctl_reg.sv
`timescale 1ns/1ps
// Control word in the bus domain. The clock fields are locked while any
// converter reports activity. Reserved prescaler codes are refused.
// Assumes wr_en and act_flags are synchronous to clk.
module adc_ctl_reg
    import adc_clk_pkg::*;
#(
    parameter int N_ADC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  ctl_word_t                      wr_word,
    input  logic [N_ADC*FLAGS_PER_ADC-1:0] act_flags,
    output ctl_word_t                      ctl_q
);
    localparam int FLAG_W = N_ADC * FLAGS_PER_ADC;

    logic cfg_lock;

    // Lock the clock fields when any activity flag of any converter is high.
    always_comb cfg_lock = |act_flags;

    // Register update: the channel flags always take a write, the clock fields take it only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q.iref_on   <= wr_word.iref_on;
            ctl_q.tsens_on  <= wr_word.tsens_on;
            ctl_q.batmon_on <= wr_word.batmon_on;
            if (!cfg_lock) begin
                ctl_q.mode <= wr_word.mode;
                if (code_valid(wr_word.presc))
                    ctl_q.presc <= wr_word.presc;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (ctl_q == '0));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (act_flags != FLAG_W'(0))) |=> ($stable(ctl_q.mode) && $stable(ctl_q.presc)));

    // R6
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_word.presc) >= NUM_CODES)) |=> $stable(ctl_q.presc));

    // R2
    chan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q.iref_on == $past(wr_word.iref_on) &&
                   ctl_q.tsens_on == $past(wr_word.tsens_on) &&
                   ctl_q.batmon_on == $past(wr_word.batmon_on)));
endmodule

// File: rtl/adc_bus_div.sv
`timescale 1ns/1ps
// Free-running binary counter on the bus clock. Tap k has a period of
// 2^(k+1) bus cycles with a 50% duty cycle.
module adc_bus_div #(
    parameter int TAPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] taps
);
    logic [TAPS-1:0] cnt_q;

    // Count every bus cycle. Each bit of the count is a divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign taps = cnt_q;

    // R7
    tap0_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (taps[0] != $past(taps[0])));

    // R7
    tap1_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(taps[1]) |-> $past(taps[0]));
endmodule

// File: rtl/adc_kern_div.sv
`timescale 1ns/1ps
// Kernel-domain prescaler. The prescaler code is brought in through two
// flops, which is safe because it only changes while the converters are idle.
// Code 0 passes the kernel clock through. Every other code toggles a flop
// once per half_count cycles, which gives an even ratio with a 50% duty cycle.
module adc_kern_div
    import adc_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_async,
    output logic               clk_out
);
    logic [PRESC_W-1:0] code_s1, code_s2;
    logic [HALF_W-1:0]  half_w, cnt_q;
    logic               div_q, bypass;

    // Two-flop synchronizer for the prescaler code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_s1 <= '0;
            code_s2 <= '0;
        end else begin
            code_s1 <= presc_async;
            code_s2 <= code_s1;
        end
    end

    // Decode the synchronized code into a half-period count and a bypass flag.
    always_comb begin
        half_w = half_count(code_s2);
        bypass = (code_s2 == '0);
    end

    // Half-period counter. The >= compare recovers when the ratio shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q >= half_w - 1'b1) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Select the pass-through clock or the divided one.
    assign clk_out = bypass ? clk : div_q;

    // R3
    div_edge_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> (cnt_q == '0));
endmodule

// File: rtl/adc_clk_sel.sv
`timescale 1ns/1ps
// Selects the conversion clock source from the mode field. The output is an
// AND-OR of the candidate clocks. Glitch-free switching is not provided,
// because the mode only changes while the converters are idle.
module adc_clk_sel
    import adc_clk_pkg::*;
(
    input  logic                clk_bus,
    input  logic                rst_n,
    input  ckmode_e             mode,
    input  logic                kern_clk,
    input  logic [BUS_TAPS-1:0] bus_taps,
    output logic                clk_out
);
    localparam int NUM_SRC = 1 << MODE_W;

    logic [NUM_SRC-1:0] sel_oh, cand;

    // One-hot decode of the mode field.
    always_comb begin
        sel_oh       = '0;
        sel_oh[mode] = 1'b1;
    end

    // Candidate clocks, in mode order.
    assign cand = {bus_taps, clk_bus, kern_clk};

    // AND-OR merge of the selected candidate.
    always_comb begin
        clk_out = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            clk_out = clk_out | (sel_oh[i] & cand[i]);
    end

    // R4
    one_source_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $onehot(sel_oh));
endmodule

// File: rtl/adc_clkgen_top.sv
`timescale 1ns/1ps
// Top of the ADC clock generator: the control word, the bus divider, the
// kernel prescaler and the source select. Assumes the resets are synchronous
// to their own clocks and are released with both clocks running.
module adc_clkgen_top
    import adc_clk_pkg::*;
#(
    parameter int N_ADC = 2
) (
    input  logic                           clk_bus,
    input  logic                           rst_bus_n,
    input  logic                           clk_kern,
    input  logic                           rst_kern_n,
    input  logic                           wr_en,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [N_ADC*FLAGS_PER_ADC-1:0] act_flags,
    output logic [WORD_W-1:0]              rd_data,
    output logic                           ch_iref_en,
    output logic                           ch_tsens_en,
    output logic                           ch_batmon_en,
    output logic                           adc_clk
);
    ctl_word_t             wr_word, ctl_q;
    logic [BUS_TAPS-1:0]   bus_taps;
    logic                  kern_clk_div;

    assign wr_word = ctl_word_t'(wr_data);

    adc_ctl_reg #(.N_ADC(N_ADC)) u_ctl (
        .clk       (clk_bus),
        .rst_n     (rst_bus_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .act_flags (act_flags),
        .ctl_q     (ctl_q)
    );

    adc_bus_div #(.TAPS(BUS_TAPS)) u_bus_div (
        .clk   (clk_bus),
        .rst_n (rst_bus_n),
        .taps  (bus_taps)
    );

    adc_kern_div u_kern_div (
        .clk         (clk_kern),
        .rst_n       (rst_kern_n),
        .presc_async (ctl_q.presc),
        .clk_out     (kern_clk_div)
    );

    adc_clk_sel u_sel (
        .clk_bus  (clk_bus),
        .rst_n    (rst_bus_n),
        .mode     (ctl_q.mode),
        .kern_clk (kern_clk_div),
        .bus_taps (bus_taps),
        .clk_out  (adc_clk)
    );

    assign rd_data      = ctl_q;
    assign ch_iref_en   = ctl_q.iref_on;
    assign ch_tsens_en  = ctl_q.tsens_on;
    assign ch_batmon_en = ctl_q.batmon_on;
endmodule

// File: tb/adc_clkgen_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module adc_clkgen_top_tb_top;
    localparam int  N_ADC       = 2;
    localparam int  FLAG_W      = N_ADC * 6;
    localparam real CLK_PERIOD  = 8.0;
    localparam real KERN_PERIOD = 14.0;
    localparam int  WDOG_CYC    = 150000;

    logic              clk_bus = 1'b0, clk_kern = 1'b0;
    logic              rst_bus_n = 1'b0, rst_kern_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [8:0]        wr_data = '0;
    logic [FLAG_W-1:0] act_flags = '0;
    logic [8:0]        rd_data;
    logic              ch_iref_en, ch_tsens_en, ch_batmon_en, adc_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2.0)  clk_bus  = ~clk_bus;
    always #(KERN_PERIOD/2.0) clk_kern = ~clk_kern;

    adc_clkgen_top #(.N_ADC(N_ADC)) dut_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_kern(clk_kern),
        .rst_kern_n(rst_kern_n), .wr_en(wr_en), .wr_data(wr_data),
        .act_flags(act_flags), .rd_data(rd_data), .ch_iref_en(ch_iref_en),
        .ch_tsens_en(ch_tsens_en), .ch_batmon_en(ch_batmon_en), .adc_clk(adc_clk)
    );

    // Builds a control word: mode [1:0], prescaler [5:2], iref 6, tsens 7, batmon 8.
    function automatic logic [8:0] word(input int mode, input int presc,
                                        input bit ir, input bit ts, input bit bm);
        return {bm, ts, ir, 4'(presc), 2'(mode)};
    endfunction

    // Divide ratio of each prescaler code, taken from the requirement.
    function automatic int ratio_of(input int code);
        int r[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
        return r[code];
    endfunction

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input realtime act, input realtime exp);
        total++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            bad++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    // One write strobe. rd_data is sampled at the falling edge after the capture edge.
    task automatic write_word(input logic [8:0] w);
        @(negedge clk_bus);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk_bus);
        wr_en   = 1'b0;
    endtask

    // Times one full period and the high phase of adc_clk.
    task automatic measure(output realtime per, output realtime hi);
        realtime t0, t1, t2;
        @(posedge adc_clk);
        @(posedge adc_clk); t0 = $realtime;
        @(negedge adc_clk); t1 = $realtime;
        @(posedge adc_clk); t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic t_reset;
        realtime p, h;
        rst_bus_n = 0; rst_kern_n = 0;
        repeat (4) @(posedge clk_kern);
        @(negedge clk_bus);
        rst_bus_n = 1; rst_kern_n = 1;
        @(negedge clk_bus);
        chk_int("R1 reset word", rd_data, 0);
        chk_int("R1 reset channels", {ch_iref_en, ch_tsens_en, ch_batmon_en}, 0);
        measure(p, h);
        chk_time("R1 reset clock period", p, KERN_PERIOD);
    endtask

    task automatic t_fields;
        logic [8:0] pats[4] = '{word(0,0,1,0,0), word(0,0,0,1,0), word(0,0,0,0,1), word(2,9,1,1,1)};
        foreach (pats[i]) begin
            write_word(pats[i]);
            chk_int("R2 readback", rd_data, pats[i]);
            chk_int("R2 channel outputs", {ch_batmon_en, ch_tsens_en, ch_iref_en}, pats[i][8:6]);
        end
        write_word('0);
    endtask

    task automatic t_presc;
        realtime p, h;
        for (int c = 0; c < 12; c++) begin
            write_word(word(0, c, 0, 0, 0));
            repeat (600) @(posedge clk_kern);
            measure(p, h);
            chk_time($sformatf("R3 period code %0d", c), p, KERN_PERIOD * ratio_of(c));
            if (c != 0)
                chk_time($sformatf("R3 high phase code %0d", c), h, KERN_PERIOD * ratio_of(c) / 2.0);
        end
    endtask

    task automatic t_sync_modes;
        realtime p, h;
        int div[3] = '{1, 2, 4};
        for (int m = 1; m <= 3; m++) begin
            write_word(word(m, 11, 0, 0, 0));
            repeat (10) @(posedge clk_bus);
            measure(p, h);
            chk_time($sformatf("R4 mode %0d period", m), p, CLK_PERIOD * div[m-1]);
            chk_time($sformatf("R7 mode %0d high phase", m), h, CLK_PERIOD * div[m-1] / 2.0);
        end
    endtask

    task automatic t_lock;
        realtime p, h;
        write_word(word(2, 3, 0, 0, 0));
        for (int b = 0; b < FLAG_W; b++) begin
            @(negedge clk_bus);
            act_flags    = '0;
            act_flags[b] = 1'b1;
            write_word(word(1, 5, b[0], 1, 0));
            chk_int($sformatf("R5 locked flag %0d", b), rd_data, word(2, 3, b[0], 1, 0));
        end
        measure(p, h);
        chk_time("R5 clock kept under lock", p, CLK_PERIOD * 2);
        @(negedge clk_bus);
        act_flags = '0;
        write_word(word(3, 6, 0, 0, 1));
        chk_int("R8 write after release", rd_data, word(3, 6, 0, 0, 1));
    endtask

    task automatic t_reserved;
        write_word(word(0, 4, 0, 0, 0));
        for (int c = 12; c < 16; c++) begin
            write_word(word(c % 4, c, 1, 0, c[0]));
            chk_int($sformatf("R6 reserved code %0d", c), rd_data, word(c % 4, 4, 1, 0, c[0]));
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        for (int i = 0; i < WDOG_CYC && !done; i++) @(posedge clk_bus);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fields();
        t_presc();
        t_sync_modes();
        t_lock();
        t_reserved();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule